// File: doc/BRIEF.md
# Chunked 8-bit floating-point dot-product engine

The block takes a stream of operand pairs in a compact 8-bit floating-point format, multiplies each pair exactly and sums the products in a 16-bit floating-point format. The sum is built in two levels. Products first add into a chunk sum. When the chunk holds the configured number of elements, or when the element flagged as last arrives, the chunk sum is added into a running stream total. This keeps small products from being lost against a large running total, even though no adder is wider than 16 bits.

When the last-flagged element is accepted, the block presents the total in two forms: the 16-bit sum, and the same value rounded to the 8-bit format for the next stage. The result is held until it is accepted. The accumulators then start again from zero for the next stream. Operands come in on a valid/ready handshake, and the block stalls new operands while a result waits.

Top module: `fp8_chunk_dot`

## Requirements
- R1: Operand bytes are decoded as sign bit 7, exponent bits 6:2 (bias 15) and mantissa bits 1:0. A nonzero exponent e gives (1.mm)·2^(e-15), including e=31, which is an ordinary finite number. Exponent 0 gives (0.mm)·2^-14.
- R2: Each product is converted exactly into the 16-bit format, with sign bit 15, exponent bits 14:9 (bias 31) and mantissa bits 8:0. An exponent of 0 there means (0.m)·2^-30. Rounding applies only when the product lies beyond the largest finite 16-bit magnitude.
- R3: Products add into a chunk sum. The chunk sum is added into the stream total after CHUNK elements, or at the last-flagged element, whichever comes first. The chunk sum then restarts from zero.
- R4: Every 16-bit addition computes the exact sum and rounds it once, to nearest with ties to even.
- R5: The 8-bit result is the 16-bit total rounded to nearest, ties to even, in the operand format.
- R6: A magnitude beyond the largest finite value of the target format saturates to 0x7FFF/0xFFFF in the 16-bit format and to 0x7F/0xFF in the 8-bit format.
- R7: The result appears with res_valid in the cycle after the last-flagged element is accepted. res_valid, res_sum and res_fp8 stay unchanged until res_ready is high. in_ready is low while a result is pending, so operands offered in that time are not taken.
- R8: The element accepted after a delivered result starts a new stream from a zero total.
- R9: After reset, res_valid is low and in_ready is high.
- R10: A zero result is encoded as +0 (0x0000 and 0x00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand pair is offered |
| in_ready | output | 1 | Block can take an operand pair |
| in_a | input | 8 | First operand, 8-bit float |
| in_b | input | 8 | Second operand, 8-bit float |
| in_last | input | 1 | This pair ends the stream |
| res_valid | output | 1 | Result is available |
| res_ready | input | 1 | Consumer takes the result |
| res_sum | output | 16 | Stream total, 16-bit float |
| res_fp8 | output | 8 | Stream total rounded to 8-bit float |

## Verification
On every cycle, the assertions check that a pending result stays stable until it is taken. They also check that a result only follows an accepted last-flagged element, that the chunk counter stays in range, that a result never carries a negative zero, and that the two result encodings agree in sign. Arithmetic correctness can only be shown by the directed scenarios, each with hand-derived encodings:
- exact products and signed cancellation
- subnormal operands
- saturation in both formats
- ties in the 8-bit rounding
- a case where chunked summation keeps small products that a single running sum would lose

// File: rtl/fp8_chunk_dot.sv
module fp8_chunk_dot #(
  parameter int CHUNK = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_a,
  input  logic [7:0]  in_b,
  input  logic        in_last,
  output logic        res_valid,
  input  logic        res_ready,
  output logic [15:0] res_sum,
  output logic [7:0]  res_fp8
);

  localparam int W  = 77;
  localparam int CW = (CHUNK > 1) ? $clog2(CHUNK) : 1;
  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [CW-1:0] CLAST = CW'(CHUNK - 1);

  // Magnitudes are fixed point with lsb weight 2^-39 (smallest 16-bit subnormal).
  function automatic logic [W-1:0] mag16(input logic [15:0] x);
    int sh;
    sh = (x[14:9] == 6'd0) ? 0 : int'(x[14:9]) - 1;
    return W'({x[14:9] != 6'd0, x[8:0]}) << sh;
  endfunction

  function automatic logic [31:0] round_code(input logic [W-1:0] m, input int off,
                                             input int mb, input logic [31:0] maxc);
    int p, s;
    logic [31:0] code;
    logic [W-1:0] kept, rem, half;
    p = -1;
    for (int i = 0; i < W; i++) if (m[i]) p = i;
    if (p < 0) return 32'd0;
    if (p >= off + mb) begin
      s = p - mb;
      code = 32'(p - off - mb) << mb;
    end else begin
      s = off;
      code = 32'd0;
    end
    kept = m >> s;
    code = code + kept[31:0];
    rem  = m & ((ONE << s) - ONE);
    half = (s == 0) ? '0 : (ONE << (s - 1));
    if (s > 0 && (rem > half || (rem == half && kept[0]))) code = code + 32'd1;
    if (code > maxc) code = maxc;
    return code;
  endfunction

  function automatic logic [15:0] pack16(input logic sgn, input logic [W-1:0] m);
    logic [31:0] c;
    c = round_code(m, 0, 9, 32'h7FFF);
    return {sgn && (c != 32'd0), c[14:0]};
  endfunction

  function automatic logic [15:0] add16(input logic [15:0] a, input logic [15:0] b);
    logic [W-1:0] ma, mb;
    ma = mag16(a);
    mb = mag16(b);
    if (a[15] == b[15]) return pack16(a[15], ma + mb);
    if (ma >= mb)       return pack16(a[15], ma - mb);
    return pack16(b[15], mb - ma);
  endfunction

  function automatic logic [15:0] mul8(input logic [7:0] a, input logic [7:0] b);
    logic [5:0] prod;
    int sh;
    prod = {3'd0, a[6:2] != 5'd0, a[1:0]} * {3'd0, b[6:2] != 5'd0, b[1:0]};
    sh = 7 + ((a[6:2] == 5'd0) ? 0 : int'(a[6:2]) - 1)
           + ((b[6:2] == 5'd0) ? 0 : int'(b[6:2]) - 1);
    return pack16(a[7] ^ b[7], W'(prod) << sh);
  endfunction

  function automatic logic [7:0] to8(input logic [15:0] x);
    logic [31:0] c;
    c = round_code(mag16(x), 23, 2, 32'h7F);
    return {x[15] && (c != 32'd0), c[6:0]};
  endfunction

  logic [CW-1:0] cnt;
  logic [15:0]   chunk, total;
  logic [15:0]   prod16, csum, tsum;
  logic          accept, flush;

  assign in_ready = !res_valid;
  assign accept   = in_valid && in_ready;
  assign prod16   = mul8(in_a, in_b);
  assign csum     = add16(chunk, prod16);
  assign flush    = in_last || (cnt == CLAST);
  assign tsum     = add16(total, csum);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      chunk     <= '0;
      total     <= '0;
      res_valid <= 1'b0;
      res_sum   <= '0;
      res_fp8   <= '0;
    end else begin
      if (res_valid && res_ready) res_valid <= 1'b0;
      if (accept) begin
        if (flush) begin
          cnt   <= '0;
          chunk <= '0;
          if (in_last) begin
            total     <= '0;
            res_valid <= 1'b1;
            res_sum   <= tsum;
            res_fp8   <= to8(tsum);
          end else begin
            total <= tsum;
          end
        end else begin
          cnt   <= cnt + CW'(1);
          chunk <= csum;
        end
      end
    end
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_sum) && $stable(res_fp8));
  p_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $past(in_valid && in_ready && in_last));
  p_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) < CHUNK);
  p_posz_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_sum != 16'h8000 && res_fp8 != 8'h80);
  p_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fp8 != 8'h00 |-> res_fp8[7] == res_sum[15]);

endmodule

// File: tb/tb_fp8_chunk_dot.sv
`timescale 1ns/1ps
module tb_fp8_chunk_dot;
  localparam int CH = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, res_ready = 1'b0;
  logic [7:0] in_a = '0, in_b = '0;
  logic in_ready, res_valid;
  logic [15:0] res_sum;
  logic [7:0] res_fp8;
  int checks = 0, errors = 0;

  fp8_chunk_dot #(.CHUNK(CH)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_last(in_last), .res_valid(res_valid),
    .res_ready(res_ready), .res_sum(res_sum), .res_fp8(res_fp8));

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] a, input logic [7:0] b, input logic last);
    in_a = a; in_b = b; in_last = last; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic take(input string tag, input logic [15:0] e16, input logic [7:0] e8);
    check({tag, " valid"}, 16'(res_valid), 16'd1);
    check({tag, " sum"}, res_sum, e16);
    check({tag, " fp8"}, 16'(res_fp8), 16'(e8));
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    check({tag, " released"}, 16'(res_valid), 16'd0);
  endtask

  task automatic t_reset();
    check("R9 res_valid", 16'(res_valid), 16'd0);
    check("R9 in_ready", 16'(in_ready), 16'd1);
  endtask

  task automatic t_basic();
    push(8'h3E, 8'h40, 1'b1);                 // 1.5*2 = 3
    take("R1 R2 single", 16'h4100, 8'h42);
    push(8'h40, 8'h40, 1'b0);                 // 4
    push(8'hBE, 8'h3C, 1'b1);                 // -1.5 -> 2.5
    take("R4 cancel", 16'h4080, 8'h41);
    push(8'h3C, 8'h3C, 1'b0);                 // 1
    push(8'hC0, 8'h40, 1'b1);                 // -4 -> -3
    take("R4 negative", 16'hC100, 8'hC2);
  endtask

  task automatic t_round8();
    push(8'h3C, 8'h3C, 1'b0);
    push(8'h30, 8'h3C, 1'b1);                 // 1.125, tie to even down
    take("R5 tie down", 16'h3E40, 8'h3C);
    push(8'h3D, 8'h3C, 1'b0);
    push(8'h30, 8'h3C, 1'b1);                 // 1.375, tie to even up
    take("R5 tie up", 16'h3EC0, 8'h3E);
  endtask

  task automatic t_edges();
    push(8'h01, 8'h01, 1'b1);                 // 2^-32, 16-bit subnormal
    take("R1 R2 subnormal", 16'h0080, 8'h00);
    push(8'h7F, 8'h7F, 1'b1);
    take("R6 sat pos", 16'h7FFF, 8'h7F);
    push(8'hFF, 8'h7F, 1'b1);
    take("R6 sat neg", 16'hFFFF, 8'hFF);
    push(8'h80, 8'h3C, 1'b1);                 // -0 * 1
    take("R10 zero", 16'h0000, 8'h00);
  endtask

  task automatic t_chunk();
    for (int i = 0; i < CH; i++) push(8'h4C, 8'h4C, 1'b0);    // 256 each
    for (int i = 0; i < CH; i++) push(8'h38, 8'h3C, i == CH - 1); // 0.5 each
    take("R3 R4 chunked", 16'h5201, 8'h64);  // 1026; a flat sum would give 1024
  endtask

  task automatic t_hold();
    push(8'h3E, 8'h40, 1'b1);
    in_a = 8'h7F; in_b = 8'h7F; in_last = 1'b1; in_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R7 hold valid", 16'(res_valid), 16'd1);
      check("R7 hold sum", res_sum, 16'h4100);
      check("R7 stall", 16'(in_ready), 16'd0);
    end
    in_valid = 1'b0; in_last = 1'b0;
    take("R7 after hold", 16'h4100, 8'h42);
    push(8'h3C, 8'h3C, 1'b1);
    take("R8 fresh stream", 16'h3E00, 8'h3C);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_round8();
    t_edges();
    t_chunk();
    t_hold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule